// File: doc/BRIEF.md
# Windowed watchdog timer

This block is a supervisory counter clocked from a slow, always-running clock. Software must keep it alive by writing a fixed key byte to a service register at regular intervals. If the count reaches the configured period without a valid service, the block raises a reset request for the rest of the chip. A service is accepted only during the trailing part of each period, called the open window. A key write that comes too early is treated as a sign that software has gone wrong, and it also raises the reset request.

The period is chosen by a 3-bit select from eight powers of two. The open window covers the last half, the last three quarters or the whole of the period. A standby-enable configuration bit, when low, forces the window to be fully open. The first service after reset is exempt from the window check, so boot code does not have to know where the counter stands. An interval flag rises three quarters of the way through each period, which gives software a safe cue for when to service. A build-time parameter selects the reset style: a one-cycle request after which the watchdog restarts, or a request that is held until the system reset arrives.

Top module: `win_watchdog`

## Requirements
- R1: The period P is 2^E low-speed clock cycles, where E comes from `cfg_ovf_sel`: 0→6, 1→7, 2→8, 3→9, 4→11, 5→13, 6→14, 7→16. If the counter stands at P-1 and no valid service arrives on that edge, `rst_req` is high in the following cycle.
- R2: A valid service restarts the count at 0 and keeps `rst_req` low. A valid service is a write of 0xAC while the count is at or above the closed length. The next overflow then follows P cycles later.
- R3: After the first service, a write of 0xAC while the count is below the closed length raises `rst_req` in the next cycle.
- R4: `cfg_win_sel` sets the closed length. 2'b01 closes counts 0..P/2-1. 2'b10 closes counts 0..P/4-1. 2'b11 and the reserved 2'b00 close nothing.
- R5: The first 0xAC write after reset, or after a pulsed fault, is accepted at any count below the overflow, and restarts the count.
- R6: When `cfg_win_en` is 0, the window is fully open whatever `cfg_win_sel` holds.
- R7: A write of any value other than 0xAC raises `rst_req` in the next cycle.
- R8: `intv_flag` is high from the cycle in which the count reaches 3P/4 until the next restart, and is low otherwise.
- R9: In pulse mode (HOLD_RST=0, the default), `rst_req` lasts one cycle. The count restarts from 0 and the first-write exemption is re-armed.
- R10: In hold mode (HOLD_RST=1), `rst_req` stays high and the count is frozen until `rst_n` is asserted. Later writes have no effect.
- R11: While `rst_n` is low, `rst_req` and `intv_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed counting clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_ovf_sel | input | 3 | Period select (R1 encoding) |
| cfg_win_sel | input | 2 | Open-window size select (R4 encoding) |
| cfg_win_en | input | 1 | 0 forces a fully open window |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service register write data |
| rst_req | output | 1 | Internal reset request |
| intv_flag | output | 1 | Interval flag, set at 3P/4 |

## Verification
A corrupted count or a wrong period shows up as a `rst_req` that comes too early or too late. For the shortest periods the bench catches this within 64 cycles of the bad state, and for the longest within 65,536. A wrong closed-length decode or a lost first-write marker turns a legal service into a reset, or a forbidden one into a silent restart, on the very next cycle. A flag that does not clear, or that sets late, shows on `intv_flag` at the 3P/4 boundary of the same period.

// File: rtl/wwdt_pkg.sv
`timescale 1ns/1ps
package wwdt_pkg;

   // Open-window size codes; the reserved code behaves as fully open.
   typedef enum logic [1:0] {
      WIN_RSVD = 2'b00,
      WIN_HALF = 2'b01,
      WIN_3Q   = 2'b10,
      WIN_FULL = 2'b11
   } win_sel_e;

   // Outcome of one clock edge as seen by the guard logic.
   typedef enum logic [1:0] {
      EVT_NONE    = 2'b00,
      EVT_SERVICE = 2'b01,
      EVT_FAULT   = 2'b10
   } wd_evt_e;

endpackage

// File: rtl/wwdt_period.sv
`timescale 1ns/1ps
module wwdt_period #(
   parameter int unsigned SEL_W = 3,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned EXP_TAB [2**SEL_W] = '{6, 7, 8, 9, 11, 13, 14, 16}
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] per_last,
   output logic [CNT_W-1:0] per_half,
   output logic [CNT_W-1:0] per_qtr,
   output logic [CNT_W-1:0] per_thr
);

   localparam int unsigned N_SEL = 2**SEL_W;

   logic [CNT_W-1:0] last_tab [N_SEL];
   logic [CNT_W-1:0] half_tab [N_SEL];
   logic [CNT_W-1:0] qtr_tab  [N_SEL];
   logic [CNT_W-1:0] thr_tab  [N_SEL];

   for (genvar g = 0; g < N_SEL; g++) begin : g_tab
      if (EXP_TAB[g] < 2 || EXP_TAB[g] > CNT_W) begin : g_bad_exp
         $error("wwdt_period: exponent entry outside 2..CNT_W");
      end
      localparam logic [CNT_W-1:0] LAST = CNT_W'((64'd1 << EXP_TAB[g]) - 64'd1);
      localparam logic [CNT_W-1:0] HALF = CNT_W'(64'd1 << (EXP_TAB[g] - 1));
      localparam logic [CNT_W-1:0] QTR  = CNT_W'(64'd1 << (EXP_TAB[g] - 2));
      assign last_tab[g] = LAST;
      assign half_tab[g] = HALF;
      assign qtr_tab[g]  = QTR;
      assign thr_tab[g]  = HALF + QTR;
   end

   assign per_last = last_tab[sel];
   assign per_half = half_tab[sel];
   assign per_qtr  = qtr_tab[sel];
   assign per_thr  = thr_tab[sel];

endmodule

// File: rtl/wwdt_window.sv
`timescale 1ns/1ps
module wwdt_window
   import wwdt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] per_half,
   input  logic [CNT_W-1:0] per_qtr,
   input  logic [1:0]       win_sel,
   input  logic             win_en,
   output logic             win_open
);

   win_sel_e         mode;
   logic [CNT_W-1:0] closed_len;

   always_comb begin
      mode = win_sel_e'(win_sel);
      if (!win_en) mode = WIN_FULL;
      case (mode)
         WIN_HALF: closed_len = per_half;
         WIN_3Q:   closed_len = per_qtr;
         default:  closed_len = '0;
      endcase
   end

   assign win_open = (cnt >= closed_len);

endmodule

// File: rtl/wwdt_counter.sv
`timescale 1ns/1ps
module wwdt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             freeze,
   input  logic [CNT_W-1:0] per_last,
   input  logic [CNT_W-1:0] per_thr,
   output logic [CNT_W-1:0] cnt,
   output logic             at_last,
   output logic             flag
);

   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt + 1'b1;
   assign at_last = (cnt >= per_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else if (!freeze) begin
         if (restart) begin
            cnt  <= '0;
            flag <= 1'b0;
         end else begin
            cnt <= cnt_inc;
            if (cnt_inc == per_thr) flag <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/wwdt_guard.sv
`timescale 1ns/1ps
module wwdt_guard
   import wwdt_pkg::*;
#(
   parameter int unsigned KEY_W    = 8,
   parameter int unsigned KEY      = 8'hAC,
   parameter bit          HOLD_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_data,
   input  logic             win_open,
   input  logic             at_last,
   output logic             restart,
   output logic             freeze,
   output logic             first_pend,
   output logic             rst_req
);

   localparam logic [KEY_W-1:0] KEY_V = KEY_W'(KEY);

   logic    live;
   logic    key_ok;
   logic    rst_q;
   wd_evt_e evt;

   assign key_ok = (wr_data == KEY_V);

   always_comb begin
      evt = EVT_NONE;
      if (live) begin
         if (wr_en && key_ok && (first_pend || win_open)) evt = EVT_SERVICE;
         else if (wr_en || at_last)                        evt = EVT_FAULT;
      end
   end

   assign restart = (evt != EVT_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  first_pend <= 1'b1;
      else if (evt == EVT_FAULT)   first_pend <= 1'b1;
      else if (evt == EVT_SERVICE) first_pend <= 1'b0;
   end

   if (HOLD_RST) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                rst_q <= 1'b0;
         else if (evt == EVT_FAULT) rst_q <= 1'b1;
      end
      assign live   = ~rst_q;
      assign freeze = rst_q;
   end else begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rst_q <= 1'b0;
         else        rst_q <= (evt == EVT_FAULT);
      end
      assign live   = 1'b1;
      assign freeze = 1'b0;
   end

   assign rst_req = rst_q;

endmodule

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
module win_watchdog #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned KEY_W    = 8,
   parameter int unsigned KEY      = 8'hAC,
   parameter bit          HOLD_RST = 1'b0,
   parameter int unsigned EXP_TAB [2**SEL_W] = '{6, 7, 8, 9, 11, 13, 14, 16}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] cfg_ovf_sel,
   input  logic [1:0]       cfg_win_sel,
   input  logic             cfg_win_en,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_data,
   output logic             rst_req,
   output logic             intv_flag
);

   if (KEY_W < 1 || KEY_W > 32) begin : g_bad_keyw
      $error("win_watchdog: KEY_W must be 1..32");
   end
   if (KEY_W < 32 && KEY >= (64'd1 << KEY_W)) begin : g_bad_key
      $error("win_watchdog: KEY does not fit KEY_W");
   end

   logic [CNT_W-1:0] per_last, per_half, per_qtr, per_thr;
   logic [CNT_W-1:0] cnt_q;
   logic             at_last, win_open;
   logic             do_restart, do_freeze, first_pend;

   wwdt_period #(.SEL_W(SEL_W), .CNT_W(CNT_W), .EXP_TAB(EXP_TAB)) u_period (
      .sel      (cfg_ovf_sel),
      .per_last (per_last),
      .per_half (per_half),
      .per_qtr  (per_qtr),
      .per_thr  (per_thr)
   );

   wwdt_window #(.CNT_W(CNT_W)) u_window (
      .cnt      (cnt_q),
      .per_half (per_half),
      .per_qtr  (per_qtr),
      .win_sel  (cfg_win_sel),
      .win_en   (cfg_win_en),
      .win_open (win_open)
   );

   wwdt_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (do_restart),
      .freeze   (do_freeze),
      .per_last (per_last),
      .per_thr  (per_thr),
      .cnt      (cnt_q),
      .at_last  (at_last),
      .flag     (intv_flag)
   );

   wwdt_guard #(.KEY_W(KEY_W), .KEY(KEY), .HOLD_RST(HOLD_RST)) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .win_open   (win_open),
      .at_last    (at_last),
      .restart    (do_restart),
      .freeze     (do_freeze),
      .first_pend (first_pend),
      .rst_req    (rst_req)
   );

endmodule

// File: rtl/win_watchdog_chk.sv
`timescale 1ns/1ps
module win_watchdog_chk #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned KEY_W    = 8,
   parameter int unsigned KEY      = 8'hAC,
   parameter bit          HOLD_RST = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [KEY_W-1:0] wr_data,
   input logic             cfg_win_en,
   input logic             rst_req,
   input logic             intv_flag,
   input logic             win_open,
   input logic             first_pend,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] per_last
);

   localparam logic [KEY_W-1:0] KEY_V = KEY_W'(KEY);

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && !wr_en && cnt_q >= per_last) |=> rst_req);

   // R2
   open_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && wr_en && wr_data == KEY_V && win_open) |=> (!rst_req && cnt_q == '0));

   // R3
   early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && wr_en && wr_data == KEY_V && !win_open && !first_pend) |=> rst_req);

   // R5
   first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && wr_en && wr_data == KEY_V && first_pend) |=> (!rst_req && cnt_q == '0));

   // R6
   force_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_win_en |-> win_open);

   // R7
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && wr_en && wr_data != KEY_V) |=> rst_req);

   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && wr_en && wr_data == KEY_V && (win_open || first_pend)) |=> !intv_flag);

   if (HOLD_RST) begin : g_hold_chk
      // R10
      rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_req |=> (rst_req && $stable(cnt_q)));
   end else begin : g_pulse_chk
      // R9
      rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_req && !wr_en) |=> (!rst_req && first_pend));
   end

endmodule

bind win_watchdog win_watchdog_chk #(
   .CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY), .HOLD_RST(HOLD_RST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .cfg_win_en (cfg_win_en),
   .rst_req    (rst_req),
   .intv_flag  (intv_flag),
   .win_open   (win_open),
   .first_pend (first_pend),
   .cnt_q      (cnt_q),
   .per_last   (per_last)
);

// File: tb/win_watchdog_tb.sv
`timescale 1ns/1ps
module win_watchdog_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_ovf_sel = 3'd0;
   logic [1:0] cfg_win_sel = 2'b01;
   logic       cfg_win_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rst_req, intv_flag, rst_req_h, intv_flag_h;

   always #4 clk = ~clk;

   win_watchdog u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_ovf_sel(cfg_ovf_sel), .cfg_win_sel(cfg_win_sel),
      .cfg_win_en(cfg_win_en), .wr_en(wr_en), .wr_data(wr_data),
      .rst_req(rst_req), .intv_flag(intv_flag)
   );

   win_watchdog #(.HOLD_RST(1'b1)) u_dut_hold (
      .clk(clk), .rst_n(rst_n), .cfg_ovf_sel(cfg_ovf_sel), .cfg_win_sel(cfg_win_sel),
      .cfg_win_en(cfg_win_en), .wr_en(wr_en), .wr_data(wr_data),
      .rst_req(rst_req_h), .intv_flag(intv_flag_h)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   // scoreboard queues
   bit    q_rst  [$];
   bit    q_flag [$];
   string q_tag  [$];

   // requirement-level reference state
   int m_cnt, m_P, m_closed, m_thr;
   bit m_first;

   task automatic chk(input string tag, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   // monitor: compare each expected item at the falling edge
   always @(negedge clk) begin
      if (q_tag.size() != 0) begin
         bit    er, ef;
         string t;
         er = q_rst.pop_front();
         ef = q_flag.pop_front();
         t  = q_tag.pop_front();
         n_vec++;
         if (rst_req !== er || intv_flag !== ef) begin
            n_bad++;
            $display("FAIL %s: rst_req=%0b intv_flag=%0b expected rst_req=%0b intv_flag=%0b",
                     t, rst_req, intv_flag, er, ef);
         end
      end
   end

   function automatic int exp_of(input logic [2:0] s);
      case (s)
         3'd0: return 6;   3'd1: return 7;   3'd2: return 8;   3'd3: return 9;
         3'd4: return 11;  3'd5: return 13;  3'd6: return 14;  default: return 16;
      endcase
   endfunction

   // R11 reset state check, then configure and release
   task automatic cfg(input logic [2:0] s, input logic [1:0] w, input logic en);
      rst_n = 1'b0;
      wr_en = 1'b0;
      cfg_ovf_sel = s; cfg_win_sel = w; cfg_win_en = en;
      m_P = 1 << exp_of(s);
      if (!en || w == 2'b11 || w == 2'b00) m_closed = 0;
      else if (w == 2'b01)                 m_closed = m_P / 2;
      else                                 m_closed = m_P / 4;
      m_thr = (m_P / 4) * 3;
      @(negedge clk);
      chk("R11 rst_req", rst_req, 1'b0);
      chk("R11 intv_flag", intv_flag, 1'b0);
      chk("R11 hold rst_req", rst_req_h, 1'b0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      m_cnt = 0; m_first = 1'b1;
   endtask

   // driver: apply one edge and push the expected outputs after it
   task automatic step(input bit wr, input logic [7:0] d, input string tag);
      bit fault, svc, ef;
      wr_en = wr; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      fault = 1'b0; svc = 1'b0;
      if (wr) begin
         if (d != 8'hAC)                         fault = 1'b1;
         else if (m_first || m_cnt >= m_closed)  svc = 1'b1;
         else                                    fault = 1'b1;
      end
      if (!svc && !fault && m_cnt >= m_P - 1) fault = 1'b1;
      if (fault)      begin m_cnt = 0; m_first = 1'b1; end
      else if (svc)   begin m_cnt = 0; m_first = 1'b0; end
      else            m_cnt++;
      ef = !fault && !svc && (m_cnt >= m_thr);
      q_rst.push_back(fault);
      q_flag.push_back(ef);
      q_tag.push_back(tag);
   endtask

   task automatic run_to(input int k, input string tag);
      while (m_cnt != k) step(1'b0, 8'h00, tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
   end

   initial begin
      // 50% window, period 64
      cfg(3'd0, 2'b01, 1'b1);
      run_to(5, "R8 idle");
      step(1'b1, 8'hAC, "R5 first write in closed part");
      run_to(10, "R8 idle");
      step(1'b1, 8'hAC, "R3 early write");
      run_to(3, "R9 after pulse");
      step(1'b1, 8'hAC, "R9 re-armed first write");
      run_to(40, "R8 idle");
      step(1'b1, 8'hAC, "R2 open write");
      run_to(32, "R4 idle");
      step(1'b1, 8'hAC, "R4 50% open boundary");
      run_to(31, "R4 idle");
      step(1'b1, 8'hAC, "R4 50% last closed count");
      run_to(50, "R8 flag high");
      idle(20, "R1 overflow P=64");

      // 75% window
      cfg(3'd0, 2'b10, 1'b1);
      run_to(2, "R5 idle");
      step(1'b1, 8'hAC, "R5 first write");
      run_to(15, "R4 idle");
      step(1'b1, 8'hAC, "R4 75% last closed count");
      step(1'b1, 8'hAC, "R9 re-armed first write");
      run_to(16, "R4 idle");
      step(1'b1, 8'hAC, "R4 75% open boundary");

      // enable bit low forces full window; bad key; hold variant
      cfg(3'd0, 2'b01, 1'b0);
      run_to(1, "R6 idle");
      step(1'b1, 8'hAC, "R6 first write");
      run_to(1, "R6 idle");
      step(1'b1, 8'hAC, "R6 early write accepted");
      run_to(4, "R7 idle");
      step(1'b1, 8'h55, "R7 bad key");
      chk("R10 hold raised", rst_req_h, 1'b1);
      step(1'b1, 8'hAC, "R7 after pulse");
      idle(6, "R7 idle");
      chk("R10 hold kept through writes", rst_req_h, 1'b1);
      chk("R10 hold flag frozen low", intv_flag_h, 1'b0);

      // reserved and full window codes
      cfg(3'd0, 2'b00, 1'b1);
      step(1'b1, 8'hAC, "R4 first write");
      run_to(3, "R4 idle");
      step(1'b1, 8'hAC, "R4 reserved code fully open");
      cfg(3'd0, 2'b11, 1'b1);
      step(1'b1, 8'hAC, "R4 first write");
      run_to(3, "R4 idle");
      step(1'b1, 8'hAC, "R4 full code fully open");

      // every period select runs to overflow
      for (int s = 0; s < 8; s++) begin
         cfg(3'(s), 2'b01, 1'b1);
         idle((1 << exp_of(3'(s))) + 2, "R1 period select overflow");
      end

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule